// File: doc/BRIEF.md
# Dual-Link Stream Handshake Beat Monitor

This block watches two valid/ready streaming links from the side: the link that feeds a streaming stage and the link that leaves it. It only observes. It never drives a valid, ready or data signal on either link. A beat on a link is a rising clock edge at which that link's valid and ready are both high. For each link, the block keeps a running beat count. For every beat it emits a one-cycle record that carries the beat's data word, its end-of-packet flag and the count index the beat was given.

Both links go through one shared tap design, instantiated once per link. Each link has its own named port group (`in_*` and `out_*`), and each record lane belongs to one link. A comparator checks the two counts whenever the `check_req` input is high. If the input side has seen a different number of beats than the output side at that moment, it raises a sticky mismatch flag. This is the sign that a pass-through stage has duplicated or dropped beats under backpressure. Byte strobes are not interpreted, and no other protocol rule is checked.

Top module: `stream_beat_monitor`

## Requirements
- R1: A beat on a link is counted at a rising clock edge only when that link's valid and ready are both high at that edge. The new count appears on the link's count output in the cycle after that edge.
- R2: Each counted beat produces exactly one record pulse (`*_rec_valid` high for one cycle) in the same cycle as the count update. The record's count index equals the updated count, so the first beat after reset carries index 1.
- R3: A record's data word and last flag are the values on that link's data and last inputs at the edge where the beat was counted.
- R4: The two links are counted independently. Beats on both links at the same edge are both counted, and each produces a record on its own lane.
- R5: Each count saturates at 2^CNT_W-1. It holds there on further beats, and records of those beats carry the saturated index.
- R6: When `check_req` is high at an edge and the input and output counts held before that edge differ, `mismatch` goes high in the next cycle.
- R7: `mismatch` stays high until reset. A `check_req` while the two counts are equal does not set it.
- R8: With `rst_n` low at an edge (synchronous, active low), both counts, both record pulses and `mismatch` read 0 in the next cycle.
- R9: Valid without ready, or ready without valid, counts nothing and produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both links |
| rst_n | input | 1 | Synchronous reset, active low |
| in_tvalid | input | 1 | Input-link valid (observed) |
| in_tready | input | 1 | Input-link ready (observed) |
| in_tdata | input | DATA_W | Input-link data word (observed) |
| in_tlast | input | 1 | Input-link end-of-packet flag (observed) |
| out_tvalid | input | 1 | Output-link valid (observed) |
| out_tready | input | 1 | Output-link ready (observed) |
| out_tdata | input | DATA_W | Output-link data word (observed) |
| out_tlast | input | 1 | Output-link end-of-packet flag (observed) |
| check_req | input | 1 | Request to compare the two counts at this edge |
| in_count | output | CNT_W | Saturating beat count of the input link |
| out_count | output | CNT_W | Saturating beat count of the output link |
| in_rec_valid | output | 1 | One-cycle pulse per input-link beat |
| in_rec_index | output | CNT_W | Count index of the input-link record |
| in_rec_data | output | DATA_W | Data word of the input-link record |
| in_rec_last | output | 1 | Last flag of the input-link record |
| out_rec_valid | output | 1 | One-cycle pulse per output-link beat |
| out_rec_index | output | CNT_W | Count index of the output-link record |
| out_rec_data | output | DATA_W | Data word of the output-link record |
| out_rec_last | output | 1 | Last flag of the output-link record |
| mismatch | output | 1 | Sticky count-mismatch flag |

## Verification
Every result of this block is due exactly one register stage after the edge that causes it. Counts, record fields and the mismatch flag are all registered once. The bench therefore drives the links and `check_req` at a falling edge, lets one rising edge pass, and samples at the next falling edge. Its expected counts come from a saturating model that it updates with the stimulus it applied at that edge. The expected mismatch is computed from the model counts as they stood before that update, because the comparator looks at the counts held before the edge.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    // Identity of the two observed links; also the lane index inside the top.
    typedef enum logic {
        LINK_IN  = 1'b0,
        LINK_OUT = 1'b1
    } link_e;

    localparam int unsigned LINK_COUNT = 2;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_CNT_W  = 16;

endpackage

// File: rtl/sbm_beat_tap.sv
module sbm_beat_tap #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tvalid,
    input  logic              tready,
    input  logic [DATA_W-1:0] tdata,
    input  logic              tlast,
    output logic [CNT_W-1:0]  cnt,
    output logic              rec_valid,
    output logic [CNT_W-1:0]  rec_index,
    output logic [DATA_W-1:0] rec_data,
    output logic              rec_last
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              rec_v;
        logic [CNT_W-1:0]  rec_idx;
        logic [DATA_W-1:0] rec_data;
        logic              rec_last;
    } tap_s;

    tap_s tap_d, tap_q;
    logic beat;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        tap_d       = tap_q;
        tap_d.rec_v = 1'b0;
        beat        = tvalid && tready;
        cnt_next    = (tap_q.cnt == CNT_MAX) ? CNT_MAX : tap_q.cnt + 1'b1;
        if (beat) begin
            tap_d.cnt      = cnt_next;
            tap_d.rec_v    = 1'b1;
            tap_d.rec_idx  = cnt_next;
            tap_d.rec_data = tdata;
            tap_d.rec_last = tlast;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else begin
            tap_q <= tap_d;
        end
    end

    assign cnt       = tap_q.cnt;
    assign rec_valid = tap_q.rec_v;
    assign rec_index = tap_q.rec_idx;
    assign rec_data  = tap_q.rec_data;
    assign rec_last  = tap_q.rec_last;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> $past(tvalid && tready));

    // R2
    rec_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_index == cnt));

    // R9
    idle_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tvalid && tready) |=> (!rec_valid && $stable(cnt)));

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/sbm_count_compare.sv
module sbm_count_compare #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_req,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    output logic             mismatch
);

    typedef struct packed {
        logic mm;
    } cmp_s;

    cmp_s cmp_d, cmp_q;

    always_comb begin
        cmp_d = cmp_q;
        if (check_req && (cnt_a != cnt_b)) begin
            cmp_d.mm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign mismatch = cmp_q.mm;

    // R7
    mm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> mismatch);

    // R6
    mm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mismatch) |-> $past(check_req && (cnt_a != cnt_b)));

endmodule

// File: rtl/stream_beat_monitor.sv
module stream_beat_monitor
    import sbm_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_tvalid,
    input  logic              in_tready,
    input  logic [DATA_W-1:0] in_tdata,
    input  logic              in_tlast,
    input  logic              out_tvalid,
    input  logic              out_tready,
    input  logic [DATA_W-1:0] out_tdata,
    input  logic              out_tlast,
    input  logic              check_req,
    output logic [CNT_W-1:0]  in_count,
    output logic [CNT_W-1:0]  out_count,
    output logic              in_rec_valid,
    output logic [CNT_W-1:0]  in_rec_index,
    output logic [DATA_W-1:0] in_rec_data,
    output logic              in_rec_last,
    output logic              out_rec_valid,
    output logic [CNT_W-1:0]  out_rec_index,
    output logic [DATA_W-1:0] out_rec_data,
    output logic              out_rec_last,
    output logic              mismatch
);

    localparam int unsigned NL = LINK_COUNT;

    logic [NL-1:0]     lane_v, lane_r, lane_l;
    logic [DATA_W-1:0] lane_dat [NL];
    logic [CNT_W-1:0]  lane_cnt [NL];
    logic [NL-1:0]     lane_rv, lane_rl;
    logic [CNT_W-1:0]  lane_ri  [NL];
    logic [DATA_W-1:0] lane_rd  [NL];

    assign lane_v[LINK_IN]    = in_tvalid;
    assign lane_r[LINK_IN]    = in_tready;
    assign lane_l[LINK_IN]    = in_tlast;
    assign lane_dat[LINK_IN]  = in_tdata;
    assign lane_v[LINK_OUT]   = out_tvalid;
    assign lane_r[LINK_OUT]   = out_tready;
    assign lane_l[LINK_OUT]   = out_tlast;
    assign lane_dat[LINK_OUT] = out_tdata;

    for (genvar g = 0; g < NL; g++) begin : g_tap
        sbm_beat_tap #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W)
        ) tap_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .tvalid    (lane_v[g]),
            .tready    (lane_r[g]),
            .tdata     (lane_dat[g]),
            .tlast     (lane_l[g]),
            .cnt       (lane_cnt[g]),
            .rec_valid (lane_rv[g]),
            .rec_index (lane_ri[g]),
            .rec_data  (lane_rd[g]),
            .rec_last  (lane_rl[g])
        );
    end

    sbm_count_compare #(
        .CNT_W (CNT_W)
    ) cmp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .check_req (check_req),
        .cnt_a     (lane_cnt[LINK_IN]),
        .cnt_b     (lane_cnt[LINK_OUT]),
        .mismatch  (mismatch)
    );

    assign in_count      = lane_cnt[LINK_IN];
    assign out_count     = lane_cnt[LINK_OUT];
    assign in_rec_valid  = lane_rv[LINK_IN];
    assign in_rec_index  = lane_ri[LINK_IN];
    assign in_rec_data   = lane_rd[LINK_IN];
    assign in_rec_last   = lane_rl[LINK_IN];
    assign out_rec_valid = lane_rv[LINK_OUT];
    assign out_rec_index = lane_ri[LINK_OUT];
    assign out_rec_data  = lane_rd[LINK_OUT];
    assign out_rec_last  = lane_rl[LINK_OUT];

    // R4
    lane_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tvalid && in_tready && out_tvalid && out_tready) |=> (in_rec_valid && out_rec_valid));

endmodule

// File: tb/stream_beat_monitor_tb_top.sv
module stream_beat_monitor_tb_top;

    localparam int unsigned DW = 32;
    localparam int unsigned CW = 4;
    localparam int unsigned MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iv = 0, ir = 0, il = 0, ov = 0, orr = 0, ol = 0, chk = 0;
    logic [DW-1:0] id = '0, od = '0;
    logic [CW-1:0] in_count, out_count, in_rec_index, out_rec_index;
    logic in_rec_valid, in_rec_last, out_rec_valid, out_rec_last, mismatch;
    logic [DW-1:0] in_rec_data, out_rec_data;

    int checks = 0;
    int errors = 0;
    int exp_in = 0, exp_out = 0;
    logic exp_mm = 0;
    logic done = 0;

    always #4 clk = ~clk;

    stream_beat_monitor #(.DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_tvalid(iv), .in_tready(ir), .in_tdata(id), .in_tlast(il),
        .out_tvalid(ov), .out_tready(orr), .out_tdata(od), .out_tlast(ol),
        .check_req(chk),
        .in_count(in_count), .out_count(out_count),
        .in_rec_valid(in_rec_valid), .in_rec_index(in_rec_index),
        .in_rec_data(in_rec_data), .in_rec_last(in_rec_last),
        .out_rec_valid(out_rec_valid), .out_rec_index(out_rec_index),
        .out_rec_data(out_rec_data), .out_rec_last(out_rec_last),
        .mismatch(mismatch)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, sample one rising edge later at the next falling edge.
    task automatic step(input logic a_v, input logic a_r, input logic [DW-1:0] a_d, input logic a_l,
                        input logic b_v, input logic b_r, input logic [DW-1:0] b_d, input logic b_l,
                        input logic c);
        logic ib, ob;
        @(negedge clk);
        iv = a_v; ir = a_r; id = a_d; il = a_l;
        ov = b_v; orr = b_r; od = b_d; ol = b_l; chk = c;
        if (c && (exp_in != exp_out)) exp_mm = 1'b1;
        ib = a_v && a_r;
        ob = b_v && b_r;
        if (ib && exp_in < MAXC) exp_in++;
        if (ob && exp_out < MAXC) exp_out++;
        @(negedge clk);
        check("R1", "in_count", in_count, exp_in);
        check("R4", "out_count", out_count, exp_out);
        check("R9", "in_rec_valid", in_rec_valid, ib);
        check("R4", "out_rec_valid", out_rec_valid, ob);
        if (ib) begin
            check("R2", "in_rec_index", in_rec_index, exp_in);
            check("R3", "in_rec_data", in_rec_data, a_d);
            check("R3", "in_rec_last", in_rec_last, a_l);
        end
        if (ob) begin
            check("R2", "out_rec_index", out_rec_index, exp_out);
            check("R3", "out_rec_data", out_rec_data, b_d);
            check("R3", "out_rec_last", out_rec_last, b_l);
        end
        check("R6", "mismatch", mismatch, exp_mm);
        iv = 0; ir = 0; ov = 0; orr = 0; chk = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_in = 0; exp_out = 0; exp_mm = 1'b0;
        check("R8", "in_count", in_count, 0);
        check("R8", "out_count", out_count, 0);
        check("R8", "in_rec_valid", in_rec_valid, 0);
        check("R8", "out_rec_valid", out_rec_valid, 0);
        check("R8", "mismatch", mismatch, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        do_reset();
        // R7: request with equal counts leaves the flag low
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R1 R9 R4: every valid/ready combination on both links, two passes
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 16; m++) begin
                step(m[0], m[1], 32'h1000_0000 + 32'(m * 3 + p), m[2] ^ m[0],
                     m[2], m[3], ~(32'h2000_0000 + 32'(m * 5 + p)), m[1], 0);
            end
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);                    // R7: counts equal (8/8)
        step(1, 1, 32'hCAFE_0001, 1, 0, 1, 0, 0, 0);         // input-only beat
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);                    // R6: 9 vs 8 sets flag
        step(0, 0, 0, 0, 1, 1, 32'hBEEF_0002, 1, 0);         // balance counts
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);                    // R7: stays high
        check("R7", "mismatch sticky", mismatch, 1);
        // R5: drive both links past saturation
        for (int k = 0; k < 10; k++) begin
            step(1, 1, 32'(k * 7), k[0], 1, 1, 32'(k * 11), k[1], 0);
        end
        check("R5", "in_count saturated", in_count, MAXC);
        check("R5", "out_count saturated", out_count, MAXC);
        do_reset();
        // R6: check_req in the same cycle as a beat compares pre-edge counts
        step(1, 1, 32'h0000_00AA, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule